// File: doc/BRIEF.md
# Frame Size Statistics Counter Bank

This block keeps per-direction traffic statistics for an Ethernet MAC. Each time the transmit or receive path finishes a frame it pulses a done strobe together with the frame length in bytes. The bank then updates that direction's counters in the next clock edge. It increments the packet count and adds the length to the octet total. It also increments the good-frame count and adds the length to the good-octet total. Finally it increments exactly one histogram bucket chosen by the length. The length is measured elsewhere and taken as given.

All counters are 32 bits wide and sit in a 57-word window of a 1 KiB register space. Software reads any word combinationally and can overwrite any word, for example to clear it. Words that hold error statistics are plain storage: hardware never changes them. The transmit group occupies indices 0 to 31 and the receive group starts at 32, with fixed positions inside each group.

Top module: `fstat_counter_bank`

## Requirements
- R1: After reset every one of the 57 window words reads zero.
- R2: A frame-done strobe increments that direction's packet word (transmit index 1, receive index 33), visible one clock after the strobe.
- R3: Each frame increments exactly one bucket word. Transmit uses 7 for lengths under 64, 10 for exactly 64, 11 for 65–127, 12 for 128–255, 13 for 256–511, 14 for 512–1023, 15 for 1024–2047 and 16 for 2048 or more. The receive bucket indices are 39 and 42–48 in the same order.
- R4: Each frame adds its length to that direction's octet word (transmit 17, receive 49).
- R5: Each frame increments the good-frame word (transmit 19, receive 51) and adds its length to the good-octet word (transmit 29, receive 56).
- R6: Hardware never changes any window word not named in R2–R5; only software writes do.
- R7: A word's index is (byte offset & 0x1FF)/4. Byte offsets 0x200 to 0x2E0 are in the window, and the low two offset bits are ignored. Reads outside the window return zero and writes outside it change nothing.
- R8: A software write replaces the addressed word. When it coincides with a hardware update of that word, the written value is kept.
- R9: Transmit and receive strobes in the same cycle are both applied in full.
- R10: Counters wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_done_i | input | 1 | Transmit frame completed (one-cycle strobe) |
| tx_len_i | input | LEN_W | Transmit frame length in bytes |
| rx_done_i | input | 1 | Receive frame completed (one-cycle strobe) |
| rx_len_i | input | LEN_W | Receive frame length in bytes |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data (combinational) |

## Verification
A wrong bucket decode or index table shows up at the read port one clock after the faulty frame. The wrong word moves, or the right one does not, so the bench sweeps the whole window after every clock and compares it against a behavioural model. A lost simultaneous update or a write that loses to hardware shows up in the same cycle. A carry error appears only when a counter crosses 2^32, which the bench forces by preloading words near the top. A decode that ignores the window's upper offset bit shows up as an alias: a write below the window disturbs a live counter, and the next sweep catches it.

// File: rtl/fstat_pkg.sv
`timescale 1ns/1ps
package fstat_pkg;
  localparam int NBUCK   = 8;
  localparam int GRP_SZ  = 32;

  function automatic int pkt_idx(int dir);
    return dir * GRP_SZ + 1;
  endfunction

  function automatic int oct_idx(int dir);
    return dir * GRP_SZ + 17;
  endfunction

  function automatic int ok_idx(int dir);
    return dir * GRP_SZ + 19;
  endfunction

  // good-octet word is not at the same group offset in both directions
  function automatic int okoct_idx(int dir);
    return (dir == 0) ? 29 : 56;
  endfunction

  // bucket 0 = fragment, 1..7 = 64, 65-127, ..., >=2048
  function automatic int bkt_idx(int dir, int k);
    return (k == 0) ? dir * GRP_SZ + 7 : dir * GRP_SZ + 9 + k;
  endfunction
endpackage

// File: rtl/fstat_classify.sv
`timescale 1ns/1ps
module fstat_classify #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0]            len_i,
  output logic [fstat_pkg::NBUCK-1:0] bucket_o
);
  logic [31:0] len_ext;
  assign len_ext = 32'(len_i);

  always_comb begin
    bucket_o = '0;
    if (len_ext < 32'd64)          bucket_o[0] = 1'b1;
    else if (len_ext == 32'd64)    bucket_o[1] = 1'b1;
    else if (len_ext >= 32'd2048)  bucket_o[7] = 1'b1;
    else begin
      for (int k = 2; k <= 6; k++) begin
        if (len_ext < (32'd1 << (k + 5)) && len_ext >= (32'd1 << (k + 4)))
          bucket_o[k] = 1'b1;
      end
      // 65..127 lies above the exact-64 case
      if (len_ext < 32'd128) bucket_o[2] = 1'b1;
    end
  end
endmodule

// File: rtl/fstat_dir.sv
`timescale 1ns/1ps
module fstat_dir #(
  parameter int DIR   = 0,
  parameter int CNT_W = 32,
  parameter int LEN_W = 16,
  parameter int NW    = 57
) (
  input  logic                            done_i,
  input  logic [LEN_W-1:0]                len_i,
  output logic [NW-1:0]                   hit_o,
  output logic [NW-1:0][CNT_W-1:0]        add_o,
  output logic [fstat_pkg::NBUCK-1:0]     bucket_o
);
  import fstat_pkg::*;

  localparam int I_PKT   = pkt_idx(DIR);
  localparam int I_OCT   = oct_idx(DIR);
  localparam int I_OK    = ok_idx(DIR);
  localparam int I_OKOCT = okoct_idx(DIR);

  logic [CNT_W-1:0] len_c;
  assign len_c = CNT_W'(len_i);

  fstat_classify #(.LEN_W(LEN_W)) i_classify (
    .len_i    (len_i),
    .bucket_o (bucket_o)
  );

  always_comb begin
    hit_o = '0;
    add_o = '0;
    if (done_i) begin
      hit_o[I_PKT]   = 1'b1;  add_o[I_PKT]   = CNT_W'(1);
      hit_o[I_OK]    = 1'b1;  add_o[I_OK]    = CNT_W'(1);
      hit_o[I_OCT]   = 1'b1;  add_o[I_OCT]   = len_c;
      hit_o[I_OKOCT] = 1'b1;  add_o[I_OKOCT] = len_c;
      for (int k = 0; k < NBUCK; k++) begin
        if (bucket_o[k]) begin
          hit_o[bkt_idx(DIR, k)] = 1'b1;
          add_o[bkt_idx(DIR, k)] = CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fstat_bank.sv
`timescale 1ns/1ps
module fstat_bank #(
  parameter int CNT_W = 32,
  parameter int NW    = 57,
  parameter int IDX_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NW-1:0]            hw_hit_i,
  input  logic [NW-1:0][CNT_W-1:0] hw_add_i,
  input  logic                     sw_we_i,
  input  logic [IDX_W-1:0]         sw_idx_i,
  input  logic [CNT_W-1:0]         sw_data_i,
  output logic [NW-1:0][CNT_W-1:0] cnt_o
);
  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   cnt_o[i] <= '0;
      else if (sw_we_i && sw_idx_i == IDX_W'(i))     cnt_o[i] <= sw_data_i;
      else if (hw_hit_i[i])                          cnt_o[i] <= cnt_o[i] + hw_add_i[i];
    end
  end
endmodule

// File: rtl/fstat_counter_bank.sv
`timescale 1ns/1ps
module fstat_counter_bank #(
  parameter int CNT_W    = 32,
  parameter int LEN_W    = 16,
  parameter int ADDR_W   = 10,
  parameter int WIN_BASE = 'h200,
  parameter int WIN_LAST = 'h2E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_done_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  input  logic              rx_done_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o
);
  import fstat_pkg::*;

  localparam int NW     = (WIN_LAST - WIN_BASE) / 4 + 1;
  localparam int IDX_W  = $clog2(NW);
  localparam int BASE_W = WIN_BASE / 4;
  localparam int LAST_W = WIN_LAST / 4;

  logic [1:0]                        dir_done;
  logic [1:0][LEN_W-1:0]             dir_len;
  logic [1:0][NW-1:0]                hit_d;
  logic [1:0][NW-1:0][CNT_W-1:0]     add_d;
  logic [1:0][NBUCK-1:0]             bucket_d;
  logic [NW-1:0]                     hw_hit;
  logic [NW-1:0][CNT_W-1:0]          hw_add;
  logic [NW-1:0][CNT_W-1:0]          cnt_q;

  assign dir_done = {rx_done_i, tx_done_i};
  assign dir_len  = {rx_len_i, tx_len_i};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    fstat_dir #(.DIR(d), .CNT_W(CNT_W), .LEN_W(LEN_W), .NW(NW)) i_dir (
      .done_i   (dir_done[d]),
      .len_i    (dir_len[d]),
      .hit_o    (hit_d[d]),
      .add_o    (add_d[d]),
      .bucket_o (bucket_d[d])
    );
  end

  // direction groups own disjoint words
  assign hw_hit = hit_d[0] | hit_d[1];
  assign hw_add = add_d[0] | add_d[1];

  logic [ADDR_W-3:0] off_word;
  logic [ADDR_W-3:0] rel_word;
  logic              in_win;
  logic [IDX_W-1:0]  sw_idx;
  logic              sw_we;

  assign off_word = reg_addr_i[ADDR_W-1:2];
  assign rel_word = off_word - (ADDR_W-2)'(BASE_W);
  assign in_win   = (off_word >= (ADDR_W-2)'(BASE_W)) && (off_word <= (ADDR_W-2)'(LAST_W));
  assign sw_idx   = rel_word[IDX_W-1:0];
  assign sw_we    = reg_we_i && in_win;

  fstat_bank #(.CNT_W(CNT_W), .NW(NW), .IDX_W(IDX_W)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_hit_i  (hw_hit),
    .hw_add_i  (hw_add),
    .sw_we_i   (sw_we),
    .sw_idx_i  (sw_idx),
    .sw_data_i (reg_wdata_i),
    .cnt_o     (cnt_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (in_win) reg_rdata_o = cnt_q[sw_idx];
  end
endmodule

// File: rtl/fstat_checker.sv
`timescale 1ns/1ps
module fstat_checker #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16,
  parameter int NW    = 57,
  parameter int IDX_W = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tx_done_i,
  input logic                      rx_done_i,
  input logic [LEN_W-1:0]          rx_len_i,
  input logic                      sw_we,
  input logic [IDX_W-1:0]          sw_idx,
  input logic [CNT_W-1:0]          reg_wdata_i,
  input logic [NW-1:0][CNT_W-1:0]  cnt_q,
  input logic [1:0][7:0]           bucket_d
);
  a_r2_tx_pkt_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && !(sw_we && sw_idx == IDX_W'(1))
    |=> cnt_q[1] == $past(cnt_q[1]) + CNT_W'(1));

  a_r3_one_bucket: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bucket_d[0]) == 1 && $countones(bucket_d[1]) == 1);

  a_r4_rx_octets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && !(sw_we && sw_idx == IDX_W'(49))
    |=> cnt_q[49] == $past(cnt_q[49]) + CNT_W'($past(rx_len_i)));

  a_r6_error_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_we && sw_idx == IDX_W'(0)) |=> $stable(cnt_q[0]));

  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we |=> cnt_q[$past(sw_idx)] == $past(reg_wdata_i));

  a_r9_both_dirs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && rx_done_i && !sw_we
    |=> cnt_q[1] == $past(cnt_q[1]) + CNT_W'(1) && cnt_q[33] == $past(cnt_q[33]) + CNT_W'(1));
endmodule

bind fstat_counter_bank fstat_checker #(
  .CNT_W(CNT_W), .LEN_W(LEN_W), .NW(NW), .IDX_W(IDX_W)
) i_fstat_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_done_i   (tx_done_i),
  .rx_done_i   (rx_done_i),
  .rx_len_i    (rx_len_i),
  .sw_we       (sw_we),
  .sw_idx      (sw_idx),
  .reg_wdata_i (reg_wdata_i),
  .cnt_q       (cnt_q),
  .bucket_d    (bucket_d)
);

// File: tb/test_fstat_counter_bank.sv
`timescale 1ns/1ps
module test_fstat_counter_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_done = 1'b0, rx_done = 1'b0, reg_we = 1'b0;
  logic [15:0] tx_len = '0, rx_len = '0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int errors = 0;
  int checks = 0;
  bit [31:0] model [57];

  always #2.5 clk = ~clk;

  fstat_counter_bank i_fstat_counter_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_done_i(tx_done), .tx_len_i(tx_len),
    .rx_done_i(rx_done), .rx_len_i(rx_len),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  function automatic string req_of(int i);
    if (i == 1 || i == 33) return "R2";
    if (i == 7 || i == 39 || (i >= 10 && i <= 16) || (i >= 42 && i <= 48)) return "R3";
    if (i == 17 || i == 49) return "R4";
    if (i == 19 || i == 29 || i == 51 || i == 56) return "R5";
    return "R6";
  endfunction

  function automatic int bucket_of(int len);
    if (len < 64)   return 7;
    if (len == 64)  return 10;
    if (len < 128)  return 11;
    if (len < 256)  return 12;
    if (len < 512)  return 13;
    if (len < 1024) return 14;
    if (len < 2048) return 15;
    return 16;
  endfunction

  task automatic model_frame(bit rx, int len);
    int b = rx ? 32 : 0;
    model[b + 1]++;
    model[b + 17] += 32'(len);
    model[b + 19]++;
    model[rx ? 56 : 29] += 32'(len);
    model[b + bucket_of(len)]++;
  endtask

  task automatic check(bit [31:0] act, bit [31:0] exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic read_at(int addr, output bit [31:0] v);
    reg_addr = 10'(addr);
    #0.01;
    v = reg_rdata;
  endtask

  task automatic sweep(string tag);
    bit [31:0] v;
    for (int i = 0; i < 57; i++) begin
      read_at('h200 + 4 * i, v);
      check(v, model[i], (tag == "") ? req_of(i) : tag, $sformatf("word %0d", i));
    end
  endtask

  task automatic step(bit tv, int tl, bit rv, int rl, bit we, int addr, bit [31:0] wd);
    @(negedge clk);
    tx_done = tv; tx_len = 16'(tl);
    rx_done = rv; rx_len = 16'(rl);
    reg_we = we; reg_addr = 10'(addr); reg_wdata = wd;
    @(posedge clk);
    if (tv) model_frame(0, tl);
    if (rv) model_frame(1, rl);
    if (we && addr >= 'h200 && addr <= 'h2E3) model[(addr & 'h1FF) >> 2] = wd;
    #0.5;
    tx_done = 0; rx_done = 0; reg_we = 0;
    sweep("");
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit [31:0] v, v1, v33;
    int lens [15] = '{10, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047, 2048, 60000};
    foreach (model[i]) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");

    // R2 R3 R4 R5: every bucket edge in each direction
    foreach (lens[i]) step(1, lens[i], 0, 0, 0, 0, 0);
    foreach (lens[i]) step(0, 0, 1, lens[14 - i], 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);

    // R9: both strobes in one cycle
    read_at('h204, v1); read_at('h284, v33);
    step(1, 64, 1, 1500, 0, 0, 0);
    read_at('h204, v); check(v, v1 + 1, "R9", "tx packets with rx");
    read_at('h284, v); check(v, v33 + 1, "R9", "rx packets with tx");
    read_at('h2C4, v); check(v, model[49], "R9", "rx octets with tx");

    // R8: software write beats a coincident hardware update
    step(1, 100, 0, 0, 1, 'h204, 32'h0000_1234);
    read_at('h204, v); check(v, 32'h0000_1234, "R8", "tx packets overwritten");
    step(0, 0, 1, 300, 1, 'h2C4, 32'h00AB_CDEF);
    read_at('h2C4, v); check(v, 32'h00AB_CDEF, "R8", "rx octets overwritten");

    // R10: wrap
    step(0, 0, 0, 0, 1, 'h204, 32'hFFFF_FFFF);
    step(1, 64, 0, 0, 0, 0, 0);
    read_at('h204, v); check(v, 32'h0, "R10", "tx packets wrap");
    step(0, 0, 0, 0, 1, 'h244, 32'hFFFF_FFF0);
    step(1, 32, 0, 0, 0, 0, 0);
    read_at('h244, v); check(v, 32'h10, "R10", "tx octets wrap");

    // R6: error words hold their written value across traffic
    step(0, 0, 0, 0, 1, 'h200, 32'd5);
    step(1, 700, 1, 40, 0, 0, 0);
    read_at('h200, v); check(v, 32'd5, "R6", "tx drop word held");

    // R7: window decode
    step(0, 0, 0, 0, 1, 'h004, 32'hDEAD_BEEF);
    read_at('h004, v); check(v, 32'h0, "R7", "read below window");
    step(0, 0, 0, 0, 1, 'h2E4, 32'hCAFE_F00D);
    read_at('h2E4, v); check(v, 32'h0, "R7", "read above window");
    step(0, 0, 0, 0, 1, 'h2E0, 32'h0BAD_0001);
    read_at('h2E0, v); check(v, 32'h0BAD_0001, "R7", "last window word");
    read_at('h206, v); check(v, model[1], "R7", "unaligned offset");
    step(0, 0, 0, 0, 1, 'h3FC, 32'h7777_7777);
    read_at('h1FC, v); check(v, 32'h0, "R7", "offset 0x1FC");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule